// File: doc/BRIEF.md
# Configuration Address Generator

This block accepts one configuration request at a time and turns it into dword accesses on a simple downstream bus. A request names a device, a function, a register offset, an access size and a direction. The block checks the request against the allowed ranges. It then forms a type-0 configuration address in which one address line, chosen by the device number, drives that device's select input. The block runs the bus cycles the request needs and hands back a response that carries the aligned read data, a not-found status and an abort flag.

A request that fails any range check, or that targets the host's own slot through the external path, is answered at once as not found, and no bus cycle is started. A write narrower than a dword is done as a read of the dword, a merge of the addressed byte lanes, and a write back. A target abort ends the request as not found. An aborted read returns all ones.

Top module: `cfg_addr_gen`

## Requirements
- R1: The bus address is (1 << (13 + device)) | (function << 8) | (offset & ~3). Bits 1:0 are always zero.
- R2: A request whose device number exceeds 18, or whose address (computed without truncation) is 0x100000 or more, is refused: the response is not found and no bus cycle occurs.
- R3: A function number above 7, an offset above 255, or size code 3 is refused in the same way.
- R4: Device 3 is refused unless `req_local_i` is high. With `req_local_i` high it is handled like any other device.
- R5: The size code selects the access width: 0 is one byte, 1 is two bytes, 2 is four bytes. The read result is the bus dword shifted right by 8*(offset mod 4), then masked to the access width.
- R6: A write of size code 2 at an offset with bits 1:0 equal to zero issues one bus write of `req_wdata_i` and no bus read. Every other write first reads the dword. It then writes back that dword with byte lane (offset mod 4)+i taken from byte i of `req_wdata_i`, for each i below the access width and each lane index below 4.
- R7: An abort on the read ends the request as not found, with no write cycle. A read returns 0xFFFFFFFF. An abort on the write also ends the request as not found.
- R8: `rsp_abort_o` is low from acceptance until an abort is seen. It is high during a response that followed an abort and low again after the response handshake. A not-found read response carries 0xFFFFFFFF, and a write response carries 0.
- R9: `busy_o` is high from the cycle after acceptance until the response handshake. `req_ready_o` is its inverse, and requests presented while busy are ignored.
- R10: `bus_be_o` bit (offset mod 4)+i is set for each i below the access width that stays below 4. No other bit is set.
- R11: While `bus_valid_o` is high and `bus_ready_i` is low, the bus valid, address, direction and write data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_dev_i | input | 5 | Device number |
| req_func_i | input | 4 | Function number |
| req_off_i | input | 9 | Register offset in bytes |
| req_size_i | input | 2 | Access width code |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_local_i | input | 1 | Local path, host slot allowed |
| req_wdata_i | input | 32 | Write data, low-aligned |
| busy_o | output | 1 | Request in flight |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response taken |
| rsp_rdata_o | output | 32 | Aligned read data |
| rsp_notfound_o | output | 1 | Request refused or aborted |
| rsp_abort_o | output | 1 | Abort flag |
| bus_valid_o | output | 1 | Bus access request |
| bus_write_o | output | 1 | Bus access is a write |
| bus_addr_o | output | 32 | Configuration address |
| bus_be_o | output | 4 | Requested byte lanes |
| bus_wdata_o | output | 32 | Dword to write |
| bus_ready_i | input | 1 | Bus access done |
| bus_rdata_i | input | 32 | Dword read |
| bus_abort_i | input | 1 | Target aborted, valid with ready |

## Verification
On every cycle the assertions check that the bus address stays inside the window and carries exactly one select line. They also check that bus and response signals hold while stalled, that no bus cycle runs while idle, and that the abort flag is clear at acceptance. Only the bench scenarios can show the correct address, lane extraction and merge values. The same holds for the choice between a direct write and a read-modify-write, for which requests are refused, and for the fact that a request presented while busy leaves no trace.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RSP} state_e;

  function automatic logic [3:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001;
      SZ_HALF: lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] expand(input logic [3:0] lanes);
    for (int i = 0; i < 4; i++) expand[8*i +: 8] = {8{lanes[i]}};
  endfunction
endpackage

// File: rtl/cfg_req_decode.sv
module cfg_req_decode #(
  parameter int DEV_W    = 5,
  parameter int FUNC_W   = 4,
  parameter int OFF_W    = 9,
  parameter int DEV_BASE = 13,
  parameter int MAX_DEV  = 18,
  parameter int MAX_FUNC = 7,
  parameter int MAX_OFF  = 255,
  parameter int HOST_DEV = 3,
  parameter logic [63:0] WINDOW = 64'h10_0000
) (
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              local_i,
  output logic [31:0]       addr_o,
  output logic              refuse_o,
  output logic [1:0]        sh_o,
  output logic [3:0]        be_o,
  output logic              direct_o
);
  import cfg_pkg::*;

  logic [63:0] full_addr;
  logic [7:0]  be_wide;

  always_comb begin
    full_addr = (64'd1 << (DEV_BASE + int'(dev_i)))
              | (64'(func_i) << 8)
              | (64'(off_i) & ~64'd3);
    addr_o    = full_addr[31:0];
    refuse_o  = (int'(dev_i) > MAX_DEV) || (int'(func_i) > MAX_FUNC)
             || (int'(off_i) > MAX_OFF) || (size_i == SZ_BAD)
             || (!local_i && int'(dev_i) == HOST_DEV)
             || (full_addr >= WINDOW);
    sh_o      = off_i[1:0];
    be_wide   = {4'b0, lane_mask(size_i)} << off_i[1:0];
    be_o      = be_wide[3:0];
    direct_o  = (size_i == SZ_WORD) && (off_i[1:0] == 2'd0);
  end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit (
  input  logic [1:0]  sh_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] rdata_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] extract_o,
  output logic [31:0] merged_o
);
  import cfg_pkg::*;

  logic [31:0] width_mask;
  logic [31:0] place_mask;
  logic [4:0]  bit_sh;

  always_comb begin
    bit_sh     = {sh_i, 3'b000};
    width_mask = expand(lane_mask(size_i));
    place_mask = width_mask << bit_sh;
    extract_o  = (rdata_i >> bit_sh) & width_mask;
    merged_o   = (rdata_i & ~place_mask) | ((wdata_i & width_mask) << bit_sh);
  end
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl #(
  parameter int DEV_BASE = 13,
  parameter logic [63:0] WINDOW = 64'h10_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [1:0]  req_size_i,
  input  logic [31:0] req_wdata_i,
  input  logic [31:0] dec_addr_i,
  input  logic        dec_refuse_i,
  input  logic [1:0]  dec_sh_i,
  input  logic [3:0]  dec_be_i,
  input  logic        dec_direct_i,
  output logic [1:0]  sh_o,
  output logic [1:0]  size_o,
  output logic [31:0] wdata_o,
  input  logic [31:0] extract_i,
  input  logic [31:0] merged_i,
  output logic        busy_o,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [31:0] rsp_rdata_o,
  output logic        rsp_notfound_o,
  output logic        rsp_abort_o,
  output logic        bus_valid_o,
  output logic        bus_write_o,
  output logic [31:0] bus_addr_o,
  output logic [3:0]  bus_be_o,
  output logic [31:0] bus_wdata_o,
  input  logic        bus_ready_i,
  input  logic        bus_abort_i
);
  import cfg_pkg::*;

  state_e      state_q;
  logic [31:0] addr_q, wdata_q, wbuf_q, rdata_q;
  logic [1:0]  sh_q, size_q;
  logic [3:0]  be_q;
  logic        write_q, nf_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wbuf_q  <= '0;
      rdata_q <= '0;
      sh_q    <= '0;
      size_q  <= '0;
      be_q    <= '0;
      write_q <= 1'b0;
      nf_q    <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= dec_addr_i;
          sh_q    <= dec_sh_i;
          size_q  <= req_size_i;
          be_q    <= dec_be_i;
          write_q <= req_write_i;
          wdata_q <= req_wdata_i;
          wbuf_q  <= req_wdata_i;
          abort_q <= 1'b0;
          nf_q    <= dec_refuse_i;
          rdata_q <= (dec_refuse_i && !req_write_i) ? '1 : '0;
          if (dec_refuse_i)                     state_q <= ST_RSP;
          else if (req_write_i && dec_direct_i) state_q <= ST_WR;
          else                                  state_q <= ST_RD;
        end
        ST_RD: if (bus_ready_i) begin
          if (bus_abort_i) begin
            abort_q <= 1'b1;
            nf_q    <= 1'b1;
            rdata_q <= write_q ? '0 : '1;
            state_q <= ST_RSP;
          end else if (write_q) begin
            wbuf_q  <= merged_i;
            state_q <= ST_WR;
          end else begin
            rdata_q <= extract_i;
            state_q <= ST_RSP;
          end
        end
        ST_WR: if (bus_ready_i) begin
          if (bus_abort_i) begin
            abort_q <= 1'b1;
            nf_q    <= 1'b1;
          end
          rdata_q <= '0;
          state_q <= ST_RSP;
        end
        default: if (rsp_ready_i) begin
          abort_q <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign busy_o         = (state_q != ST_IDLE);
  assign bus_valid_o    = (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_write_o    = (state_q == ST_WR);
  assign bus_addr_o     = addr_q;
  assign bus_be_o       = be_q;
  assign bus_wdata_o    = wbuf_q;
  assign rsp_valid_o    = (state_q == ST_RSP);
  assign rsp_rdata_o    = rdata_q;
  assign rsp_notfound_o = nf_q;
  assign rsp_abort_o    = abort_q;
  assign sh_o           = sh_q;
  assign size_o         = size_q;
  assign wdata_o        = wdata_q;

  // R2: any issued address lies inside the window
  p_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (64'(bus_addr_o) < WINDOW));
  // R1: exactly one device select line, low bits clear
  p_one_select_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> ($countones(bus_addr_o[31:DEV_BASE]) == 1 && bus_addr_o[1:0] == 2'b00));
  p_bus_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
                                 && $stable(bus_write_o) && $stable(bus_wdata_o));
  p_rsp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_notfound_o));
  p_idle_no_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_valid_o && !rsp_valid_o);
  p_abort_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !rsp_abort_o);
  p_abort_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_abort_o && !write_q |-> rsp_rdata_o == 32'hFFFF_FFFF);
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int DEV_W    = 5,
  parameter int FUNC_W   = 4,
  parameter int OFF_W    = 9,
  parameter int DEV_BASE = 13,
  parameter int MAX_DEV  = 18,
  parameter int MAX_FUNC = 7,
  parameter int MAX_OFF  = 255,
  parameter int HOST_DEV = 3,
  parameter logic [63:0] WINDOW = 64'h10_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [FUNC_W-1:0] req_func_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_write_i,
  input  logic              req_local_i,
  input  logic [31:0]       req_wdata_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_notfound_o,
  output logic              rsp_abort_o,
  output logic              bus_valid_o,
  output logic              bus_write_o,
  output logic [31:0]       bus_addr_o,
  output logic [3:0]        bus_be_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ready_i,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_abort_i
);
  logic [31:0] dec_addr, extract, merged, st_wdata;
  logic        dec_refuse, dec_direct;
  logic [1:0]  dec_sh, st_sh, st_size;
  logic [3:0]  dec_be;

  cfg_req_decode #(
    .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W), .DEV_BASE(DEV_BASE),
    .MAX_DEV(MAX_DEV), .MAX_FUNC(MAX_FUNC), .MAX_OFF(MAX_OFF),
    .HOST_DEV(HOST_DEV), .WINDOW(WINDOW)
  ) i_decode (
    .dev_i(req_dev_i), .func_i(req_func_i), .off_i(req_off_i),
    .size_i(req_size_i), .local_i(req_local_i),
    .addr_o(dec_addr), .refuse_o(dec_refuse), .sh_o(dec_sh),
    .be_o(dec_be), .direct_o(dec_direct)
  );

  cfg_lane_unit i_lane (
    .sh_i(st_sh), .size_i(st_size), .rdata_i(bus_rdata_i), .wdata_i(st_wdata),
    .extract_o(extract), .merged_o(merged)
  );

  cfg_ctrl #(.DEV_BASE(DEV_BASE), .WINDOW(WINDOW)) i_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_size_i, .req_wdata_i,
    .dec_addr_i(dec_addr), .dec_refuse_i(dec_refuse), .dec_sh_i(dec_sh),
    .dec_be_i(dec_be), .dec_direct_i(dec_direct),
    .sh_o(st_sh), .size_o(st_size), .wdata_o(st_wdata),
    .extract_i(extract), .merged_i(merged),
    .busy_o, .rsp_valid_o, .rsp_ready_i, .rsp_rdata_o, .rsp_notfound_o, .rsp_abort_o,
    .bus_valid_o, .bus_write_o, .bus_addr_o, .bus_be_o, .bus_wdata_o,
    .bus_ready_i, .bus_abort_i
  );
endmodule

// File: tb/test_cfg_addr_gen.sv
module test_cfg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_local = 0, rsp_ready = 0;
  logic [4:0] req_dev = 0;
  logic [3:0] req_func = 0;
  logic [8:0] req_off = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, busy, rsp_valid, rsp_nf, rsp_abort;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic bus_valid, bus_write;
  logic [3:0] bus_be;
  logic bus_ready = 0, bus_abort = 0;
  logic [31:0] bus_rdata = 0;

  int compared = 0, mismatched = 0;
  bit exp_busy = 0, exp_nobus = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_addr, last_wdata;
  logic [3:0] last_be;
  bit [31:0] mem [bit [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_addr_gen i_cfg_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_dev_i(req_dev), .req_func_i(req_func), .req_off_i(req_off), .req_size_i(req_size),
    .req_write_i(req_write), .req_local_i(req_local), .req_wdata_i(req_wdata),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_rdata_o(rsp_rdata), .rsp_notfound_o(rsp_nf), .rsp_abort_o(rsp_abort),
    .bus_valid_o(bus_valid), .bus_write_o(bus_write), .bus_addr_o(bus_addr),
    .bus_be_o(bus_be), .bus_wdata_o(bus_wdata), .bus_ready_i(bus_ready),
    .bus_rdata_i(bus_rdata), .bus_abort_i(bus_abort)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[15:0], ~a[15:0]};
  endfunction

  // target: device 1 aborts every access, device 2 aborts writes
  function automatic bit tgt_abort(input logic [31:0] a, input logic w);
    return (a[31:13] == 19'd2) || (w && a[31:13] == 19'd4);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus responder, one cycle of latency
  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready <= 0;
      bus_abort <= 0;
    end else if (bus_valid) begin
      bus_ready <= 1;
      bus_abort <= tgt_abort(bus_addr, bus_write);
      bus_rdata <= mem_rd(bus_addr);
      last_addr = bus_addr;
      last_be   = bus_be;
      if (bus_write) begin
        wr_cnt++;
        last_wdata = bus_wdata;
        if (!tgt_abort(bus_addr, 1'b1)) mem[bus_addr] = bus_wdata;
      end else rd_cnt++;
    end
  end

  // per-clock comparison of handshake state (R9)
  always @(negedge clk) if (rst_n) begin
    chk(busy === exp_busy && req_ready === !exp_busy, "R9 busy/ready", {30'b0, busy, req_ready}, {30'b0, exp_busy, !exp_busy});
    if (exp_nobus) chk(!bus_valid, "R2 no bus cycle on refusal", {31'b0, bus_valid}, 32'b0);
  end

  task automatic do_req(input int dev, input int func, input int off, input int size,
                        input bit wr, input bit loc, input logic [31:0] wd, input bit poke);
    logic [63:0] a64;
    logic [31:0] a, old, exp_rd, exp_mg;
    bit refuse, direct, ab_rd, ab_wr, nf;
    int nb, sh, exp_r, exp_w;
    logic [3:0] exp_be;
    a64 = (64'd1 << (13 + dev)) | (64'(func) << 8) | (64'(off) & ~64'd3);
    a = a64[31:0];
    refuse = dev > 18 || func > 7 || off > 255 || size == 3 || (!loc && dev == 3) || a64 >= 64'h10_0000;
    sh = off % 4;
    nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    direct = wr && size == 2 && sh == 0;
    old = mem_rd(a);
    exp_rd = 0; exp_mg = old; exp_be = 0;
    for (int i = 0; i < nb; i++) if (sh + i < 4) begin
      exp_rd[8*i +: 8] = old[8*(sh+i) +: 8];
      exp_mg[8*(sh+i) +: 8] = wd[8*i +: 8];
      exp_be[sh+i] = 1'b1;
    end
    ab_rd = !refuse && !direct && tgt_abort(a, 1'b0);
    ab_wr = !refuse && wr && !ab_rd && tgt_abort(a, 1'b1);
    nf = refuse || ab_rd || ab_wr;
    exp_r = (refuse || direct) ? 0 : 1;
    exp_w = (refuse || !wr || ab_rd) ? 0 : 1;
    rd_cnt = 0; wr_cnt = 0;

    @(negedge clk);
    req_dev = dev[4:0]; req_func = func[3:0]; req_off = off[8:0]; req_size = size[1:0];
    req_write = wr; req_local = loc; req_wdata = wd; req_valid = 1;
    exp_nobus = refuse;
    @(posedge clk);
    exp_busy = 1;
    @(negedge clk);
    if (poke) begin
      req_dev = 0; req_off = 9'h40; req_write = 1; req_size = 2;
    end else req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    req_valid = 0;
    chk(rsp_nf === nf, "R2/R3/R4/R7 notfound", {31'b0, rsp_nf}, {31'b0, nf});
    chk(rsp_abort === (ab_rd || ab_wr), "R8 abort flag", {31'b0, rsp_abort}, {31'b0, ab_rd || ab_wr});
    if (!wr) chk(rsp_rdata === (nf ? 32'hFFFF_FFFF : exp_rd), "R5/R7 read data", rsp_rdata, nf ? 32'hFFFF_FFFF : exp_rd);
    else chk(rsp_rdata === 32'h0, "R8 write response data", rsp_rdata, 32'h0);
    chk(rd_cnt == exp_r && wr_cnt == exp_w, "R6 bus cycle counts", rd_cnt * 16 + wr_cnt, exp_r * 16 + exp_w);
    if (exp_r + exp_w > 0) begin
      chk(last_addr === a, "R1 address", last_addr, a);
      chk(last_be === exp_be, "R10 byte lanes", {28'b0, last_be}, {28'b0, exp_be});
    end
    if (exp_w > 0) chk(last_wdata === exp_mg, "R6 write dword", last_wdata, exp_mg);
    rsp_ready = 1;
    @(posedge clk);
    exp_busy = 0; exp_nobus = 0;
    @(negedge clk);
    rsp_ready = 0;
    chk(rsp_abort === 1'b0, "R8 abort cleared", {31'b0, rsp_abort}, 32'b0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(rd_cnt == exp_r && wr_cnt == exp_w && !rsp_valid, "R9 request while busy ignored",
          rd_cnt * 16 + wr_cnt, exp_r * 16 + exp_w);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && req_ready && !rsp_valid && !bus_valid, "R9 reset state",
        {28'b0, busy, req_ready, rsp_valid, bus_valid}, 32'b0100);
    rst_n = 1;
    @(negedge clk);
    do_req(0, 0, 0, 2, 0, 0, 0, 0);                  // R1 R5 word read
    do_req(5, 7, 8'h3E, 1, 0, 0, 0, 0);              // R1 R5 half at lane 2
    do_req(4, 2, 8'h13, 0, 0, 0, 0, 0);              // R5 byte at lane 3
    do_req(6, 1, 8'h43, 1, 0, 0, 0, 0);              // R5 R10 half clipped
    do_req(0, 0, 8, 2, 1, 0, 32'hCAFE_F00D, 0);      // R6 direct write
    do_req(0, 0, 8, 2, 0, 0, 0, 0);                  // R6 readback
    do_req(0, 0, 9, 0, 1, 0, 32'h1234_56AB, 0);      // R6 byte merge
    do_req(0, 0, 8, 2, 0, 0, 0, 0);
    do_req(5, 3, 8'h0E, 1, 1, 0, 32'hFFFF_BEEF, 0);  // R6 half merge
    do_req(4, 0, 4'h5, 2, 1, 0, 32'h0BAD_0001, 0);   // R6 unaligned word
    do_req(7, 0, 0, 2, 0, 0, 0, 0);                  // R2 window
    do_req(19, 0, 0, 2, 0, 0, 0, 0);                 // R2 device limit
    do_req(31, 0, 0, 2, 1, 0, 1, 0);                 // R2
    do_req(0, 8, 0, 2, 0, 0, 0, 0);                  // R3 function
    do_req(0, 0, 256, 2, 0, 0, 0, 0);                // R3 offset
    do_req(0, 0, 4, 3, 0, 0, 0, 0);                  // R3 size code
    do_req(3, 0, 0, 2, 0, 0, 0, 0);                  // R4 host slot refused
    do_req(3, 0, 0, 2, 0, 1, 0, 0);                  // R4 local path
    do_req(1, 0, 4, 2, 0, 0, 0, 0);                  // R7 read abort
    do_req(1, 0, 5, 0, 1, 0, 32'h77, 0);             // R7 rmw read abort
    do_req(2, 0, 6, 1, 1, 0, 32'h5555, 0);           // R7 write abort
    do_req(0, 0, 0, 2, 0, 0, 0, 0);                  // R8 next request clean
    do_req(6, 0, 8'h20, 0, 0, 0, 0, 1);              // R9 ignored while busy
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule